// File: doc/BRIEF.md
# Collatz Trajectory Delay Engine with Pseudorandom Seeds

This block pairs a small control machine with an iterative arithmetic datapath. A 16-bit linear feedback shift register supplies starting values. For each starting value the datapath walks the Collatz trajectory one step per clock: it halves even values and maps odd values to 3n+1. It counts the steps until the value reaches 1, and that step count is the trajectory's delay.

Two level-sensitive user requests pace the sequence. `start_i` launches a trajectory from the current generator state and puts that starting value on `data_o`. The engine then computes on its own and raises `done_o` when the delay is known. `dout_i` then replaces the starting value on `data_o` with the delay, and the engine waits for the next `start_i`.

There is no data stream at either edge, so there is no valid/ready pair and no back-pressure. `data_o` is a held display value, and the two requests are plain control pins. A request that arrives in a phase that cannot take it is dropped and is not remembered.

Top module: `collatz_seed_engine`

## Requirements
- R1: Synchronous active-high reset clears `data_o` to 0 and `done_o` to 0, and reloads the generator with 0x1234. This also applies when reset arrives during a computation.
- R2: The generator advances only when a start is accepted, exactly once per trajectory. On an advance it shifts right by one, and the new bit 15 is the XOR of old bits 0, 2, 3 and 5. The first seed after reset is 0x1234 and the second is 0x091A.
- R3: `start_i` is accepted only while the engine is waiting: after reset, or after a delay has been shown. One cycle after the accepting edge, `data_o` shows the seed, which is the generator state from before the advance.
- R4: Each step halves an even value and maps an odd value n to 3n+1. `done_o` rises d+1 cycles after the start edge, where d is the number of steps needed to reach 1.
- R5: `done_o` stays high, with `data_o` still showing the seed, until `dout_i` is sampled high.
- R6: An accepted `dout_i` shows the delay d on `data_o` one cycle later and drops `done_o` in that same cycle.
- R7: `start_i` has no effect while a computation runs or while `done_o` is high. `dout_i` has no effect at any time except while `done_o` is high.
- R8: A generator state of 0 never starts a trajectory. The seed becomes 1, whose delay is 0.
- R9: The trajectory register is 32 bits wide, so 3n+1 never overflows for any 16-bit seed.
- R10: `data_o` changes only one cycle after an accepted start or an accepted `dout_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to launch the next trajectory |
| dout_i | input | 1 | Request to show the computed delay |
| done_o | output | 1 | High while a finished delay waits to be shown |
| data_o | output | 16 | Shown value: the seed, then the delay |

## Verification
The engine is driven with single-cycle requests and with requests held for several cycles, so that an accepted request can be told apart from the same level seen in a later phase. It is also given `dout_i` pulses during a computation and during the delay display, and `start_i` pulses while `done_o` waits, so that a dropped request can be told apart from a remembered one. A run of about twenty generator seeds gives trajectory lengths from short to several hundred cycles. A reset in the middle of a run shows that the generator sequence restarts. A second instance whose generator starts at zero exercises the seed substitution and the zero-step delay.

// File: rtl/collatz_pkg.sv
package collatz_pkg;

  typedef enum logic [1:0] {
    CTL_IDLE = 2'd0,
    CTL_RUN  = 2'd1,
    CTL_DONE = 2'd2,
    CTL_SHOW = 2'd3
  } ctl_state_e;

endpackage

// File: rtl/collatz_lfsr.sv
module collatz_lfsr #(
  parameter int unsigned        W    = 16,
  parameter logic [W-1:0]       INIT = 16'h1234,
  parameter logic [W-1:0]       TAPS = 16'h002D
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] state_q,
  output logic [W-1:0] seed_o
);

  logic feedback;

  assign feedback = ^(state_q & TAPS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= INIT;
    end else if (adv) begin
      state_q <= {feedback, state_q[W-1:1]};
    end
  end

  // a zero state would never leave the all-zero trajectory start; substitute 1
  assign seed_o = (state_q == '0) ? {{(W-1){1'b0}}, 1'b1} : state_q;

endmodule

// File: rtl/collatz_datapath.sv
module collatz_datapath #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TRAJ_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [DATA_W-1:0] seed,
  output logic [TRAJ_W-1:0] traj_q,
  output logic [DATA_W-1:0] steps_q,
  output logic              at_one
);

  localparam int unsigned EXT_W = TRAJ_W - DATA_W;

  logic [TRAJ_W-1:0] tripled;
  logic [TRAJ_W-1:0] halved;
  logic [TRAJ_W-1:0] traj_next;

  assign tripled   = (traj_q << 1) + traj_q + {{(TRAJ_W-1){1'b0}}, 1'b1};
  assign halved    = {1'b0, traj_q[TRAJ_W-1:1]};
  assign traj_next = traj_q[0] ? tripled : halved;
  assign at_one    = (traj_q == {{(TRAJ_W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk) begin
    if (rst) begin
      traj_q  <= {{(TRAJ_W-1){1'b0}}, 1'b1};
      steps_q <= '0;
    end else if (load) begin
      traj_q  <= {{EXT_W{1'b0}}, seed};
      steps_q <= '0;
    end else if (step && !at_one) begin
      traj_q  <= traj_next;
      steps_q <= steps_q + 1'b1;
    end
  end

endmodule

// File: rtl/collatz_ctl.sv
module collatz_ctl
  import collatz_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       dout_i,
  input  logic       at_one,
  output ctl_state_e state_q,
  output logic       load_seed,
  output logic       step_en,
  output logic       show_delay,
  output logic       done_o
);

  ctl_state_e state_d;
  logic       waiting;

  assign waiting    = (state_q == CTL_IDLE) || (state_q == CTL_SHOW);
  assign load_seed  = waiting && start_i;
  assign step_en    = (state_q == CTL_RUN);
  assign show_delay = (state_q == CTL_DONE) && dout_i;
  assign done_o     = (state_q == CTL_DONE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      CTL_IDLE: if (start_i) state_d = CTL_RUN;
      CTL_RUN:  if (at_one)  state_d = CTL_DONE;
      CTL_DONE: if (dout_i)  state_d = CTL_SHOW;
      CTL_SHOW: if (start_i) state_d = CTL_RUN;
      default:               state_d = CTL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= CTL_IDLE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/collatz_seed_engine.sv
module collatz_seed_engine #(
  parameter int unsigned            DATA_W    = 16,
  parameter int unsigned            TRAJ_W    = 32,
  parameter logic [DATA_W-1:0]      SEED_INIT = 16'h1234,
  parameter logic [DATA_W-1:0]      SEED_TAPS = 16'h002D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              dout_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  import collatz_pkg::*;

  ctl_state_e        state_q;
  logic              load_seed;
  logic              step_en;
  logic              show_delay;
  logic              at_one;
  logic [DATA_W-1:0] lfsr_q;
  logic [DATA_W-1:0] seed_w;
  logic [TRAJ_W-1:0] traj_q;
  logic [DATA_W-1:0] steps_q;
  logic [DATA_W-1:0] data_q;

  collatz_ctl u_ctl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .dout_i     (dout_i),
    .at_one     (at_one),
    .state_q    (state_q),
    .load_seed  (load_seed),
    .step_en    (step_en),
    .show_delay (show_delay),
    .done_o     (done_o)
  );

  collatz_lfsr #(
    .W    (DATA_W),
    .INIT (SEED_INIT),
    .TAPS (SEED_TAPS)
  ) u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .adv     (load_seed),
    .state_q (lfsr_q),
    .seed_o  (seed_w)
  );

  collatz_datapath #(
    .DATA_W (DATA_W),
    .TRAJ_W (TRAJ_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .load    (load_seed),
    .step    (step_en),
    .seed    (seed_w),
    .traj_q  (traj_q),
    .steps_q (steps_q),
    .at_one  (at_one)
  );

  always_ff @(posedge clk) begin
    if (rst)             data_q <= '0;
    else if (load_seed)  data_q <= seed_w;
    else if (show_delay) data_q <= steps_q;
  end

  assign data_o = data_q;

endmodule

// File: rtl/collatz_seed_engine_chk.sv
module collatz_seed_engine_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TRAJ_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              dout_i,
  input logic              done_o,
  input logic [DATA_W-1:0] data_o,
  input logic              load_seed,
  input logic              show_delay,
  input logic              step_en,
  input logic              at_one,
  input logic [DATA_W-1:0] lfsr_q,
  input logic [DATA_W-1:0] seed_w,
  input logic [DATA_W-1:0] steps_q,
  input logic [TRAJ_W-1:0] traj_q
);

  localparam logic [TRAJ_W+1:0] ODD_LIMIT = ((TRAJ_W+2)'(1) << TRAJ_W) / 3;

  // R2
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_seed |=> $stable(lfsr_q));

  // R2
  lfsr_shift_chk: assert property (@(posedge clk) disable iff (rst)
    load_seed |=> lfsr_q[DATA_W-2:0] == $past(lfsr_q[DATA_W-1:1]));

  // R3
  seed_shown_chk: assert property (@(posedge clk) disable iff (rst)
    load_seed |=> data_o == $past(seed_w));

  // R8
  seed_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    load_seed |-> seed_w != '0);

  // R4
  done_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(at_one && step_en));

  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done_o && !dout_i |=> done_o);

  // R6
  delay_shown_chk: assert property (@(posedge clk) disable iff (rst)
    done_o && dout_i |=> !done_o && data_o == $past(steps_q));

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_seed && !show_delay |=> $stable(data_o));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    step_en && !at_one && traj_q[0] |-> {2'b00, traj_q} < ODD_LIMIT);

endmodule

bind collatz_seed_engine collatz_seed_engine_chk #(
  .DATA_W (DATA_W),
  .TRAJ_W (TRAJ_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dout_i     (dout_i),
  .done_o     (done_o),
  .data_o     (data_o),
  .load_seed  (load_seed),
  .show_delay (show_delay),
  .step_en    (step_en),
  .at_one     (at_one),
  .lfsr_q     (lfsr_q),
  .seed_w     (seed_w),
  .steps_q    (steps_q),
  .traj_q     (traj_q)
);

// File: tb/test_collatz_seed_engine.sv
module test_collatz_seed_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 16;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, dout = 1'b0;
  logic zstart = 1'b0, zdout = 1'b0;
  logic done, zdone;
  logic [DATA_W-1:0] data, zdata;

  int vectors = 0, miscompares = 0, cyc = 0;
  string cur_req = "R1";
  bit started = 0;

  // behavioural reference state
  int m_lfsr, m_mode, m_rem, m_delay, m_data;
  bit m_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  collatz_seed_engine i_collatz_seed_engine (
    .clk(clk), .rst(rst), .start_i(start), .dout_i(dout), .done_o(done), .data_o(data));

  collatz_seed_engine #(.SEED_INIT(16'h0000)) i_collatz_seed_engine_zero (
    .clk(clk), .rst(rst), .start_i(zstart), .dout_i(zdout), .done_o(zdone), .data_o(zdata));

  function automatic int next_gen(int s);
    int b;
    b = ((s >> 0) ^ (s >> 2) ^ (s >> 3) ^ (s >> 5)) & 1;
    return (b << 15) | ((s & 16'hFFFF) >> 1);
  endfunction

  function automatic int steps_of(int s);
    longint n;
    int k;
    n = s; k = 0;
    while (n != 1) begin
      if (n % 2 == 0) n = n / 2; else n = 3 * n + 1;
      k++;
    end
    return k;
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // reference model: mode 0 waiting, 1 computing, 2 finished
  always @(posedge clk) begin
    started = 1;
    cyc++;
    if (rst) begin
      m_lfsr = 16'h1234; m_mode = 0; m_data = 0; m_done = 0; m_rem = 0;
    end else begin
      case (m_mode)
        0: if (start) begin
             m_data  = (m_lfsr == 0) ? 1 : m_lfsr;
             m_lfsr  = next_gen(m_lfsr);
             m_delay = steps_of(m_data);
             m_rem   = m_delay;
             m_mode  = 1;
           end
        1: if (m_rem == 0) begin m_mode = 2; m_done = 1; end
           else m_rem--;
        default: if (dout) begin m_data = m_delay; m_done = 0; m_mode = 0; end
      endcase
    end
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog expired act=hung exp=finished");
      finish_run();
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      vectors++;
      if (data !== m_data[DATA_W-1:0] || done !== m_done) begin
        miscompares++;
        $display("FAIL %s cycle %0d: data_o=%h done_o=%b exp data_o=%h done_o=%b",
                 cur_req, cyc, data, done, m_data[DATA_W-1:0], m_done);
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // one trajectory: hold start, optional early dout (R7), wait, show delay
  task automatic trajectory(int hold, bit early_dout, int gap, output int seed_seen);
    int exp_seed, guard;
    exp_seed = (m_lfsr == 0) ? 1 : m_lfsr;
    cur_req = "R3";
    start = 1'b1;
    tick(1);
    check(data == exp_seed[DATA_W-1:0], "R3 seed shown", data, exp_seed);
    seed_seen = data;
    cur_req = "R7";
    if (hold > 1) tick(hold - 1);
    start = 1'b0;
    if (early_dout) begin dout = 1'b1; tick(2); dout = 1'b0; end
    cur_req = "R4";
    guard = 0;
    while (!m_done && guard < 2000) begin tick(1); guard++; end
    cur_req = "R5";
    start = 1'b1;                     // ignored while finished (R7)
    tick(gap + 1);
    start = 1'b0;
    check(done == 1'b1, "R5 done held", done, 1);
    check(data == exp_seed[DATA_W-1:0], "R5 seed kept", data, exp_seed);
    cur_req = "R6";
    dout = 1'b1;
    tick(1);
    check(data == steps_of(exp_seed), "R6/R4 delay shown", data, steps_of(exp_seed));
    check(done == 1'b0, "R6 done cleared", done, 0);
    cur_req = "R7";
    tick(2);                          // dout still high while showing: ignored
    dout = 1'b0;
    check(data == steps_of(exp_seed), "R7 dout ignored in show", data, steps_of(exp_seed));
    tick(gap);
  endtask

  initial begin
    int s;
    tick(3);
    rst = 1'b0;
    check(data == 0, "R1 reset data", data, 0);
    check(done == 0, "R1 reset done", done, 0);
    cur_req = "R7";
    dout = 1'b1; tick(2); dout = 1'b0;
    check(data == 0, "R7 dout ignored when idle", data, 0);

    trajectory(1, 0, 0, s);
    check(s == 16'h1234, "R2 first seed", s, 16'h1234);
    trajectory(3, 1, 2, s);
    check(s == 16'h091A, "R2 second seed", s, 16'h091A);
    for (int i = 0; i < 18; i++) trajectory(1 + (i % 3), i[0], i % 4, s);

    // R1: reset in the middle of a computation
    cur_req = "R1";
    start = 1'b1; tick(1); start = 1'b0;
    tick(2);
    rst = 1'b1; tick(2); rst = 1'b0;
    check(done == 0, "R1 mid-run reset done", done, 0);
    check(data == 0, "R1 mid-run reset data", data, 0);
    trajectory(1, 0, 1, s);
    check(s == 16'h1234, "R1 generator reloaded", s, 16'h1234);

    // R8: generator stuck at zero gives seed 1 and delay 0
    for (int k = 0; k < 2; k++) begin
      zstart = 1'b1; tick(1); zstart = 1'b0;
      check(zdata == 1, "R8 zero state seeds 1", zdata, 1);
      check(zdone == 0, "R8 not yet done", zdone, 0);
      tick(1);
      check(zdone == 1, "R8 R4 done after one cycle", zdone, 1);
      zdout = 1'b1; tick(1); zdout = 1'b0;
      check(zdata == 0, "R8 delay of 1 is 0", zdata, 0);
      check(zdone == 0, "R8 done cleared", zdone, 0);
    end
    // R9 is checked by an assertion on every odd step of every trajectory
    // R10 is covered by the per-cycle comparison of data_o
    tick(2);
    finish_run();
  end

endmodule